// File: doc/BRIEF.md
# Shifted Constant Former and Adder

This unit executes one instruction form used to build wide constants and addresses in a 64-bit datapath. The instruction carries a 16-bit immediate, a two-bit shift selector, an upper-fill bit, a lower-fill bit and an add-enable bit. The unit places the immediate at one of four 16-bit lanes. It fills every bit above the immediate with the upper-fill bit. If the lower-fill bit is set, it fills every bit below the immediate with ones. The result is either that constant alone (move form) or the constant added to the current destination register value (add form). One move followed by three adds can form any 64-bit value.

The shift selector is decoded with its low bit inverted, so an all-zero selector means a 16-bit shift. Zero shift is reached only with the selector value that has its low bit set. When that zero-shift encoding appears with add, upper fill and lower fill all clear, the word belongs to a different instruction. The unit flags the word and refuses to write. Results are registered and appear one clock after the valid strobe. No carry or overflow status is produced.

Top module: `lconst_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_wen and out_conflict are 0 and out_result is all zeros.
- R2: The major opcode sits in instruction bits 31:26 and must equal 6'h06. The shift amount is 16 times the two-bit value {bit 17, inverted bit 16}. Selector bits 17/16 = 0/0 give 16, 0/1 give 0, 1/1 give 32 and 1/0 give 48.
- R3: The immediate is bits 15:0 and the upper-fill bit is bit 19. The constant is the 17-bit value {bit 19, immediate}, sign-extended to 64 bits and shifted left by the shift amount.
- R4: The lower-fill bit is bit 18. When it is set, every bit below the shift amount in the constant is 1. With zero shift, or with the bit clear, no low bits are filled.
- R5: The add-enable bit is bit 20. When it is set, out_result is the constant plus in_rd, modulo 2^64.
- R6: When add-enable is clear, out_result equals the constant and in_rd has no effect.
- R7: A matching word with zero shift and bits 20, 19 and 18 all clear raises out_conflict for one cycle. out_wen stays 0 and out_result keeps its previous value.
- R8: A word whose opcode is not 6'h06 raises neither out_wen nor out_conflict, and out_result keeps its previous value.
- R9: Outputs follow in_valid by exactly one clock. In a cycle after in_valid was low, out_wen and out_conflict are 0.
- R10: Additions wrap silently past 2^64, and no carry or overflow output exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and register value are valid this cycle |
| in_insn | input | 32 | Instruction word |
| in_rd | input | 64 | Current value of the destination register |
| out_result | output | 64 | Registered result value |
| out_wen | output | 1 | Result is to be written to the destination register |
| out_conflict | output | 1 | Word carried the colliding zero-shift encoding |

## Verification
The bench exercises all four selector codes. A design that decoded the low selector bit without inversion would place the immediate a lane off and give wrong values in every case. Lower fill is tried at zero shift and at the widest shift, where an unguarded subtract-one would flood the whole word with ones. Upper fill is tried at the widest shift, where its ones must fall off the top. The add form is driven across a 2^64 wrap and into an exact zero sum, which exposes a carry that leaks into the upper lane. The colliding encoding and a foreign opcode are each sent after a known result; a design that wrote, flagged the wrong word or let the result change would show it at the ports.

// File: rtl/lconst_pkg.sv
package lconst_pkg;
  parameter int INSN_W  = 32;
  parameter int DATA_W  = 64;
  parameter int IMM_W   = 16;
  parameter int SEL_W   = 2;
  parameter int OPC_W   = 6;
  parameter logic [OPC_W-1:0] OPC_VAL = 6'h06;

  localparam int LANES = 1 << SEL_W;

  typedef struct packed {
    logic             add_en;
    logic             fill_hi;
    logic             fill_lo;
    logic [SEL_W-1:0] sh_sel;
    logic [IMM_W-1:0] imm;
  } fields_t;
endpackage

// File: rtl/lconst_decode.sv
module lconst_decode
  import lconst_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output fields_t           fld_o,
  output logic              match_o,
  output logic              write_o,
  output logic              conflict_o
);
  localparam int OPC_LSB = INSN_W - OPC_W;

  logic zero_shift;
  logic no_mods;

  always_comb begin
    match_o        = (insn_i[INSN_W-1:OPC_LSB] == OPC_VAL);
    fld_o.add_en   = insn_i[20];
    fld_o.fill_hi  = insn_i[19];
    fld_o.fill_lo  = insn_i[18];
    fld_o.sh_sel   = {insn_i[17], ~insn_i[16]};
    fld_o.imm      = insn_i[IMM_W-1:0];
    zero_shift     = (fld_o.sh_sel == '0);
    no_mods        = !fld_o.add_en && !fld_o.fill_hi && !fld_o.fill_lo;
    conflict_o     = match_o && zero_shift && no_mods;
    write_o        = match_o && !conflict_o;
  end
endmodule

// File: rtl/lconst_build.sv
module lconst_build
  import lconst_pkg::*;
(
  input  fields_t           fld_i,
  output logic [DATA_W-1:0] const_o
);
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] shifted [LANES];
  logic [DATA_W-1:0] lowmask [LANES];

  assign base = {{(DATA_W-IMM_W){fld_i.fill_hi}}, fld_i.imm};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int SHAMT = g * IMM_W;
    assign shifted[g] = base << SHAMT;
    assign lowmask[g] = (DATA_W'(1) << SHAMT) - DATA_W'(1);
  end

  always_comb begin
    const_o = shifted[fld_i.sh_sel];
    if (fld_i.fill_lo) const_o = const_o | lowmask[fld_i.sh_sel];
  end

  always_comb begin
    if (fld_i.fill_lo === 1'b1 && fld_i.sh_sel != '0)
      a_r4_low_fill: assert (const_o[IMM_W-1:0] == {IMM_W{1'b1}});
    if (fld_i.fill_hi === 1'b1 && fld_i.sh_sel != SEL_W'(LANES-1))
      a_r3_upper_fill: assert (const_o[DATA_W-1] == 1'b1);
  end
endmodule

// File: rtl/lconst_stage.sv
module lconst_stage
  import lconst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              conflict_i,
  input  logic              add_en_i,
  input  logic [DATA_W-1:0] const_i,
  input  logic [DATA_W-1:0] rd_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wen_o,
  output logic              conflict_o
);
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] result_d;
  logic              wen_d;
  logic              conflict_d;
  logic              res_en;

  always_comb begin
    sum        = const_i + (add_en_i ? rd_i : '0);
    res_en     = valid_i && write_i;
    result_d   = sum;
    wen_d      = res_en;
    conflict_d = valid_i && conflict_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o   <= '0;
      wen_o      <= 1'b0;
      conflict_o <= 1'b0;
    end else begin
      wen_o      <= wen_d;
      conflict_o <= conflict_d;
      if (res_en) result_o <= result_d;
    end
  end

  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> $stable(result_o));
endmodule

// File: rtl/lconst_unit.sv
module lconst_unit
  import lconst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [DATA_W-1:0] in_rd,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wen,
  output logic              out_conflict
);
  fields_t           fld;
  logic              match;
  logic              write;
  logic              conflict;
  logic [DATA_W-1:0] cval;
  logic              unused_dst;

  assign unused_dst = ^in_insn[25:21];

  lconst_decode u_dec (
    .insn_i     (in_insn),
    .fld_o      (fld),
    .match_o    (match),
    .write_o    (write),
    .conflict_o (conflict)
  );

  lconst_build u_build (
    .fld_i   (fld),
    .const_o (cval)
  );

  lconst_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (in_valid),
    .write_i    (write),
    .conflict_i (conflict),
    .add_en_i   (fld.add_en),
    .const_i    (cval),
    .rd_i       (in_rd),
    .result_o   (out_result),
    .wen_o      (out_wen),
    .conflict_o (out_conflict)
  );

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_wen && !out_conflict));

  a_r8_foreign_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_insn[31:26] != OPC_VAL) |=> (!out_wen && !out_conflict));

  a_r7_conflict_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_conflict |-> !out_wen);
endmodule

// File: tb/lconst_unit_test.sv
`timescale 1ns/1ps
module lconst_unit_test;
  typedef struct packed {
    logic        a;
    logic        u;
    logic        l;
    logic        s1;
    logic        s2;
    logic [15:0] k;
    logic [63:0] rd;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam logic [63:0] R0 = 64'h1111_2222_3333_4444;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,16'hf060,R0,64'hffff_ffff_f060_0000},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,16'h7fff,R0,64'h0000_7fff_ffff_ffff},
    '{1'b0,1'b1,1'b1,1'b1,1'b1,16'h0000,R0,64'hffff_0000_ffff_ffff},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h1234,R0,64'h1234_0000_0000_0000},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,16'h5678,64'h1234_0000_0000_0000,64'h1234_5678_0000_0000},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h9abc,64'h1234_5678_0000_0000,64'h1234_5678_9abc_0000},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,16'hdef0,64'h1234_5678_9abc_0000,64'h1234_5678_9abc_def0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,16'h8000,R0,64'h0000_0000_0000_8000},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h8000,R0,64'hffff_ffff_ffff_8000},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,16'h0001,R0,64'h0001_ffff_ffff_ffff},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,16'hffff,64'h0002_0000_0000_0005,64'h0001_0000_0000_0005},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,16'hffff,64'h0000_0000_0001_0000,64'h0000_0000_0000_0000},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,R0,64'h0000_0000_0000_ffff}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_insn;
  logic [63:0] in_rd;
  logic [63:0] out_result;
  logic        out_wen;
  logic        out_conflict;

  int total;
  int bad;
  bit done;

  lconst_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .in_rd(in_rd), .out_result(out_result), .out_wen(out_wen),
    .out_conflict(out_conflict)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mk(input logic [5:0] op, input logic a, input logic u,
                                     input logic l, input logic s1, input logic s2,
                                     input logic [15:0] k);
    return {op, 5'd3, a, u, l, s1, s2, k};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] insn, input logic [63:0] rd);
    @(negedge clk);
    in_insn  = insn;
    in_rd    = rd;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; in_rd = '0;
    repeat (3) @(negedge clk);
    chk("R1 result in reset", out_result, 64'h0);
    chk("R1 wen in reset", {63'h0, out_wen}, 64'h0);
    chk("R1 conflict in reset", {63'h0, out_conflict}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wen after reset", {63'h0, out_wen}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      issue(mk(6'h06, VECS[i].a, VECS[i].u, VECS[i].l, VECS[i].s1, VECS[i].s2, VECS[i].k),
            VECS[i].rd);
      chk($sformatf("R2 R3 R4 R5 R6 R10 vector %0d result", i), out_result, VECS[i].exp);
      chk($sformatf("R9 vector %0d wen", i), {63'h0, out_wen}, 64'h1);
      chk($sformatf("R9 vector %0d conflict", i), {63'h0, out_conflict}, 64'h0);
    end

    // R9: idle cycle after a valid word
    @(negedge clk);
    chk("R9 idle wen", {63'h0, out_wen}, 64'h0);

    // R6: move form ignores rd
    issue(mk(6'h06, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00ab), 64'hffff_ffff_ffff_ffff);
    chk("R6 rd ignored", out_result, 64'h0000_0000_00ab_0000);

    // R7: colliding encoding
    issue(mk(6'h06, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1357), 64'h5);
    chk("R7 conflict flag", {63'h0, out_conflict}, 64'h1);
    chk("R7 no write", {63'h0, out_wen}, 64'h0);
    chk("R7 result held", out_result, 64'h0000_0000_00ab_0000);
    @(negedge clk);
    chk("R7 conflict one cycle", {63'h0, out_conflict}, 64'h0);

    // R8: foreign opcode carrying the colliding field pattern
    issue(mk(6'h05, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h2468), 64'h7);
    chk("R8 no conflict", {63'h0, out_conflict}, 64'h0);
    chk("R8 no write", {63'h0, out_wen}, 64'h0);
    chk("R8 result held", out_result, 64'h0000_0000_00ab_0000);
    issue(mk(6'h26, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h2468), 64'h7);
    chk("R8 other opcode held", out_result, 64'h0000_0000_00ab_0000);

    // R1: reset in the middle clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset result", out_result, 64'h0);
    rst_n = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule